// File: doc/BRIEF.md
# Memory Error Capture and Interrupt Unit

The unit sits beside a memory pipeline and watches for three kinds of faulting request: an address that decodes to nothing, a request that hits an invalid translation page, and a request that breaks a security rule. Each kind arrives as a one-cycle pulse. The pulse carries the requesting client's 6-bit identifier, a write flag and the faulting address. A security fault also carries a type flag. For each kind the unit holds the first fault it sees and raises a pending bit. The enabled pending bits drive a registered interrupt line.

Software reads the captured record over a simple word-addressed register port. Each record is a status word followed by its address word. Software then writes ones to the pending bits to acknowledge them. While a kind is still pending, later faults of that kind are dropped, so the record always describes the first fault. The three kinds use different status layouts so that an existing decoder can read each one.

Register word map: 0 pending (bit 0 decode, bit 1 page, bit 2 security, write-one-to-clear), 1 enable mask (bits 2:0), 2/3 decode status/address, 4/5 page status/address, 6/7 security status/address. Reads of unmapped words return zero.

Top module: `memerr_capture_unit`

## Requirements
- R1: After reset, every register word reads zero and `irq_o` is low.
- R2: The decode-fault status word holds the client ID in bits 5:0 and the write flag in bit 31. All other bits are zero.
- R3: The page-fault status word holds the write flag in bit 0 and the client ID in bits 6:1. All other bits are zero.
- R4: The security-fault status word holds the client ID in bits 5:0, the type flag in bit 30 and the write flag in bit 31. All other bits are zero.
- R5: Each kind's faulting address reads from the word directly after that kind's status word.
- R6: While a kind's pending bit is set and not being cleared, a new fault of that kind leaves its status and address unchanged.
- R7: Writing word 0 clears exactly the pending bits written as one. Bits written as zero are unaffected.
- R8: If a fault arrives in the same cycle that its pending bit is cleared, the new fault is captured and the bit remains set.
- R9: `irq_o` is high one cycle after any pending bit is set together with its mask bit, and low one cycle after no such pair exists.
- R10: Once a kind's pending bit is cleared, the next fault of that kind is captured again.
- R11: A pending bit is set by a fault whatever the mask holds. The mask word reads back its low 3 bits and zeros above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| err_vld_i | input | 3 | Fault pulse per kind (0 decode, 1 page, 2 security) |
| err_cid_i | input | 18 | Client ID per kind, 6 bits each, kind 0 lowest |
| err_wr_i | input | 3 | Write flag per kind |
| err_addr_i | input | 96 | Faulting address per kind, ADDR_W bits each |
| err_sec_type_i | input | 1 | Security violation type flag |
| reg_addr_i | input | 3 | Register word index |
| reg_wen_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| irq_o | output | 1 | Interrupt line, registered |

## Verification
A fault pulse presented before a rising edge is in the pending bit and the record after that edge. The bench therefore reads them at the following falling edge. Reads are combinational, so the bench samples them one time step after setting the word index. `irq_o` carries one more register stage. After a fault or a mask write, the bench first confirms the line has not moved yet, then checks the new level one cycle later. The same-cycle clear and capture case is driven at a single edge and read at the next falling edge.

// File: rtl/memerr_pkg.sv
package memerr_pkg;

    localparam int NCLS  = 3;
    localparam int CID_W = 6;
    localparam int DW    = 32;
    localparam int NREG  = 2 + 2 * NCLS;
    localparam int RA_W  = $clog2(NREG);

    localparam int RA_PEND = 0;
    localparam int RA_MASK = 1;
    localparam int RA_CAP  = 2;

    typedef enum int {
        CLS_DECODE = 0,
        CLS_PAGE   = 1,
        CLS_SECURE = 2
    } err_cls_e;

    typedef struct packed {
        logic [CID_W-1:0] cid;
        logic             wr;
        logic             sec_ty;
    } err_info_t;

    // Builds the status word for one fault kind in that kind's own layout.
    function automatic logic [DW-1:0] pack_status(input int cls, input err_info_t info);
        logic [DW-1:0] s;
        s = '0;
        case (cls)
            CLS_DECODE: begin
                s[CID_W-1:0] = info.cid;
                s[DW-1]      = info.wr;
            end
            CLS_PAGE: begin
                s[0]       = info.wr;
                s[CID_W:1] = info.cid;
            end
            default: begin
                s[CID_W-1:0] = info.cid;
                s[DW-2]      = info.sec_ty;
                s[DW-1]      = info.wr;
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/memerr_regbank.sv
module memerr_regbank
    import memerr_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic            wen_i,
    input  logic [RA_W-1:0] waddr_i,
    input  logic [DW-1:0]   wdata_i,
    input  logic [NCLS-1:0] vld_i,
    output logic [NCLS-1:0] clr_o,
    output logic [NCLS-1:0] pend_o,
    output logic [NCLS-1:0] mask_o
);

    logic [NCLS-1:0] pend_q;
    logic [NCLS-1:0] mask_q;

    always_comb begin
        clr_o = '0;
        if (wen_i && waddr_i == RA_W'(RA_PEND))
            clr_o = wdata_i[NCLS-1:0];
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            pend_q <= '0;
            mask_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_o) | vld_i;
            if (wen_i && waddr_i == RA_W'(RA_MASK))
                mask_q <= wdata_i[NCLS-1:0];
        end
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;

endmodule

// File: rtl/memerr_slot.sv
module memerr_slot
    import memerr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CLS    = 0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              vld_i,
    input  err_info_t         info_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              pend_i,
    input  logic              clr_i,
    output logic [DW-1:0]     stat_o,
    output logic [DW-1:0]     addr_o
);

    logic take;
    assign take = vld_i && (!pend_i || clr_i);

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            stat_o <= '0;
            addr_o <= '0;
        end else if (take) begin
            stat_o <= pack_status(CLS, info_i);
            addr_o <= DW'(addr_i);
        end
    end

endmodule

// File: rtl/memerr_capture_unit.sv
module memerr_capture_unit
    import memerr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic [NCLS-1:0]        err_vld_i,
    input  logic [NCLS*CID_W-1:0]  err_cid_i,
    input  logic [NCLS-1:0]        err_wr_i,
    input  logic [NCLS*ADDR_W-1:0] err_addr_i,
    input  logic                   err_sec_type_i,
    input  logic [RA_W-1:0]        reg_addr_i,
    input  logic                   reg_wen_i,
    input  logic [DW-1:0]          reg_wdata_i,
    output logic [DW-1:0]          reg_rdata_o,
    output logic                   irq_o
);

    logic [NCLS-1:0]    clr_w;
    logic [NCLS-1:0]    pend_q;
    logic [NCLS-1:0]    mask_q;
    logic [NCLS*DW-1:0] stat_flat;
    logic [NCLS*DW-1:0] addr_flat;

    memerr_regbank u_regs (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .wen_i   (reg_wen_i),
        .waddr_i (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .vld_i   (err_vld_i),
        .clr_o   (clr_w),
        .pend_o  (pend_q),
        .mask_o  (mask_q)
    );

    for (genvar g = 0; g < NCLS; g++) begin : g_slot
        err_info_t info;
        assign info.cid    = err_cid_i[g*CID_W +: CID_W];
        assign info.wr     = err_wr_i[g];
        assign info.sec_ty = (g == CLS_SECURE) ? err_sec_type_i : 1'b0;

        memerr_slot #(.ADDR_W(ADDR_W), .CLS(g)) u_slot (
            .clk_i  (clk_i),
            .rst_i  (rst_i),
            .vld_i  (err_vld_i[g]),
            .info_i (info),
            .addr_i (err_addr_i[g*ADDR_W +: ADDR_W]),
            .pend_i (pend_q[g]),
            .clr_i  (clr_w[g]),
            .stat_o (stat_flat[g*DW +: DW]),
            .addr_o (addr_flat[g*DW +: DW])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        if (reg_addr_i == RA_W'(RA_PEND))
            reg_rdata_o = DW'(pend_q);
        else if (reg_addr_i == RA_W'(RA_MASK))
            reg_rdata_o = DW'(mask_q);
        for (int k = 0; k < NCLS; k++) begin
            if (reg_addr_i == RA_W'(RA_CAP + 2 * k))
                reg_rdata_o = stat_flat[k*DW +: DW];
            if (reg_addr_i == RA_W'(RA_CAP + 2 * k + 1))
                reg_rdata_o = addr_flat[k*DW +: DW];
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) irq_o <= 1'b0;
        else       irq_o <= |(pend_q & mask_q);
    end

endmodule

// File: rtl/memerr_chk.sv
module memerr_chk
    import memerr_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NCLS-1:0]    vld,
    input logic [NCLS-1:0]    clr,
    input logic [NCLS-1:0]    pend,
    input logic [NCLS-1:0]    mask,
    input logic [NCLS*DW-1:0] stat,
    input logic [NCLS*DW-1:0] addr,
    input logic               irq
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (pend == '0 && !irq));

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|(pend & mask)) |=> irq);

    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(pend & mask)) |=> !irq);

    for (genvar i = 0; i < NCLS; i++) begin : g_cls
        // R6
        hold_record_chk: assert property (@(posedge clk) disable iff (rst)
            (pend[i] && !clr[i]) |=> ($stable(stat[i*DW +: DW]) && $stable(addr[i*DW +: DW])));

        // R7
        w1c_drop_chk: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && !vld[i]) |=> !pend[i]);

        // R8
        clear_race_chk: assert property (@(posedge clk) disable iff (rst)
            (clr[i] && vld[i]) |=> pend[i]);
    end

endmodule

bind memerr_capture_unit memerr_chk u_chk (
    .clk  (clk_i),
    .rst  (rst_i),
    .vld  (err_vld_i),
    .clr  (clr_w),
    .pend (pend_q),
    .mask (mask_q),
    .stat (stat_flat),
    .addr (addr_flat),
    .irq  (irq_o)
);

// File: tb/memerr_capture_unit_tb_top.sv
module memerr_capture_unit_tb_top;
    import memerr_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 32;

    logic                   clk = 1'b0;
    logic                   rst;
    logic [NCLS-1:0]        err_vld_i;
    logic [NCLS*CID_W-1:0]  err_cid_i;
    logic [NCLS-1:0]        err_wr_i;
    logic [NCLS*ADDR_W-1:0] err_addr_i;
    logic                   err_sec_type_i;
    logic [RA_W-1:0]        reg_addr_i;
    logic                   reg_wen_i;
    logic [DW-1:0]          reg_wdata_i;
    logic [DW-1:0]          reg_rdata_o;
    logic                   irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    memerr_capture_unit #(.ADDR_W(ADDR_W)) dut_i (
        .clk_i          (clk),
        .rst_i          (rst),
        .err_vld_i      (err_vld_i),
        .err_cid_i      (err_cid_i),
        .err_wr_i       (err_wr_i),
        .err_addr_i     (err_addr_i),
        .err_sec_type_i (err_sec_type_i),
        .reg_addr_i     (reg_addr_i),
        .reg_wen_i      (reg_wen_i),
        .reg_wdata_i    (reg_wdata_i),
        .reg_rdata_o    (reg_rdata_o),
        .irq_o          (irq_o)
    );

    typedef struct packed {
        logic [1:0]  cls;
        logic [5:0]  cid;
        logic        wr;
        logic        st;
        logic [31:0] addr;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VEC [7] = '{
        '{2'd0, 6'h2a, 1'b1, 1'b0, 32'h8000_1000, 32'h8000_002a},
        '{2'd0, 6'h05, 1'b0, 1'b1, 32'h0000_0040, 32'h0000_0005},
        '{2'd1, 6'h33, 1'b1, 1'b1, 32'h1234_5678, 32'h0000_0067},
        '{2'd1, 6'h01, 1'b0, 1'b0, 32'hffff_fffc, 32'h0000_0002},
        '{2'd2, 6'h3f, 1'b1, 1'b1, 32'hdead_beec, 32'hc000_003f},
        '{2'd2, 6'h10, 1'b0, 1'b0, 32'h0000_0004, 32'h0000_0010},
        '{2'd2, 6'h00, 1'b0, 1'b1, 32'h0000_0800, 32'h4000_0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        reg_addr_i = RA_W'(a);
        #1;
        v = reg_rdata_o;
    endtask

    task automatic chk_reg(input string tag, input int a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_addr_i  = RA_W'(a);
        reg_wdata_i = d;
        reg_wen_i   = 1'b1;
        @(negedge clk);
        reg_wen_i   = 1'b0;
    endtask

    task automatic set_err(input int cls, input logic [5:0] cid, input logic w,
                           input logic st, input logic [31:0] a);
        err_vld_i[cls]              = 1'b1;
        err_cid_i[cls*CID_W +: CID_W] = cid;
        err_wr_i[cls]               = w;
        err_addr_i[cls*ADDR_W +: ADDR_W] = a;
        err_sec_type_i              = st;
    endtask

    task automatic pulse(input int cls, input logic [5:0] cid, input logic w,
                         input logic st, input logic [31:0] a);
        @(negedge clk);
        set_err(cls, cid, w, st, a);
        @(negedge clk);
        err_vld_i = '0;
    endtask

    initial begin
        rst            = 1'b1;
        err_vld_i      = '0;
        err_cid_i      = '0;
        err_wr_i       = '0;
        err_addr_i     = '0;
        err_sec_type_i = 1'b0;
        reg_addr_i     = '0;
        reg_wen_i      = 1'b0;
        reg_wdata_i    = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < NREG; a++) chk_reg("R1 reg after reset", a, 32'h0);
        chk("R1 irq after reset", {31'b0, irq_o}, 32'h0);

        // Table walk: layouts (R2/R3/R4), address word (R5), W1C (R7)
        for (int n = 0; n < 7; n++) begin
            vec_t v;
            int c;
            string tag;
            v   = VEC[n];
            c   = int'(v.cls);
            tag = (c == 0) ? "R2 decode status" : (c == 1) ? "R3 page status" : "R4 security status";
            pulse(c, v.cid, v.wr, v.st, v.addr);
            chk_reg(tag, RA_CAP + 2 * c, v.exp);
            chk_reg("R5 address word", RA_CAP + 2 * c + 1, v.addr);
            chk_reg("R11 pending set while masked", RA_PEND, 32'(1 << c));
            wr(RA_PEND, 32'(1 << c));
            chk_reg("R7 pending cleared", RA_PEND, 32'h0);
        end

        // R6: first fault held while pending
        pulse(1, 6'h05, 1'b0, 1'b0, 32'h0000_0100);
        pulse(1, 6'h09, 1'b1, 1'b0, 32'h0000_0200);
        chk_reg("R6 status held", RA_CAP + 2, 32'h0000_000a);
        chk_reg("R6 address held", RA_CAP + 3, 32'h0000_0100);
        wr(RA_PEND, 32'h2);
        // R10: capture resumes after clear
        pulse(1, 6'h09, 1'b1, 1'b0, 32'h0000_0200);
        chk_reg("R10 status recaptured", RA_CAP + 2, 32'h0000_0013);
        chk_reg("R10 address recaptured", RA_CAP + 3, 32'h0000_0200);
        wr(RA_PEND, 32'h2);

        // R8: clear and new fault in the same cycle
        pulse(0, 6'h03, 1'b0, 1'b0, 32'h0000_0010);
        pulse(2, 6'h11, 1'b0, 1'b0, 32'h0000_0030);
        @(negedge clk);
        set_err(0, 6'h07, 1'b1, 1'b0, 32'h0000_0020);
        reg_addr_i  = RA_W'(RA_PEND);
        reg_wdata_i = 32'h1;
        reg_wen_i   = 1'b1;
        @(negedge clk);
        err_vld_i = '0;
        reg_wen_i = 1'b0;
        chk_reg("R8 new fault status", RA_CAP, 32'h8000_0007);
        chk_reg("R8 new fault address", RA_CAP + 1, 32'h0000_0020);
        chk_reg("R8 pending kept", RA_PEND, 32'h5);
        // R7: only ones clear
        wr(RA_PEND, 32'h1);
        chk_reg("R7 selective clear", RA_PEND, 32'h4);
        chk_reg("R7 record untouched", RA_CAP + 4, 32'h0000_0011);
        wr(RA_PEND, 32'h4);
        chk_reg("R7 all clear", RA_PEND, 32'h0);

        // R9 / R11: masking and interrupt timing
        pulse(1, 6'h02, 1'b0, 1'b0, 32'h0000_0400);
        @(negedge clk);
        chk("R9 masked bit gives no irq", {31'b0, irq_o}, 32'h0);
        chk_reg("R11 pending with mask clear", RA_PEND, 32'h2);
        wr(RA_MASK, 32'h2);
        chk_reg("R11 mask readback", RA_MASK, 32'h2);
        chk("R9 irq one cycle behind mask", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R9 irq raised", {31'b0, irq_o}, 32'h1);
        wr(RA_PEND, 32'h2);
        chk("R9 irq one cycle behind clear", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        chk("R9 irq dropped", {31'b0, irq_o}, 32'h0);
        wr(RA_MASK, 32'hffff_ffff);
        chk_reg("R11 mask upper bits zero", RA_MASK, 32'h7);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule